// File: doc/BRIEF.md
# Neuromorphic Custom Instruction Dispatcher

This block sits in the execute stage of a small integer core. It examines each issued 32-bit instruction word and decides where the instruction goes. A word whose major opcode is the custom-0 value is split into four operations by its funct3 field:

- a load of the neuron model coefficients;
- a load of the step-size select, the voltage clamp flag and the decay time constant select;
- a neuron state update;
- a synaptic decay.

Every other opcode is handed to the standard ALU path. The block also rejects the four unused funct3 codes of custom-0 as illegal.

The two load operations write a set of configuration registers held inside the block. Those registers keep their values across any number of later instructions, and they drive the arithmetic units through the configuration outputs. The update and decay operations write back to the register file; the two loads do not.

The neuron update uses its destination register twice. That register supplies the packed state word, and the same register receives the new state word together with the spike flag. For this operation the block therefore also requests a read of that register.

Top module: `nm_dispatch`

## Requirements
- R1: When issue_i is high and instr_i[6:0] equals 7'b0001011, the instruction is treated as custom. When issue_i is high and instr_i[6:0] is any other value, only sel_alu_o is asserted: no custom select, no write-back, no illegal flag and no configuration change.
- R2: A custom instruction with funct3 (instr_i[14:12]) = 3'b000 loads the coefficients on the next clock edge, from rs1 and rs2 as follows. cfg_a_o takes rs1_val_i[31:16] and cfg_b_o takes rs1_val_i[15:0]. cfg_c_o takes rs2_val_i[31:16] and cfg_d_o takes rs2_val_i[15:0].
- R3: A custom instruction with funct3 = 3'b001 loads three fields from rs1 on the next clock edge. cfg_step_o takes rs1_val_i[0], cfg_clamp_o takes rs1_val_i[1], and cfg_tau_o takes rs1_val_i[3:2]. The coefficients are left unchanged.
- R4: A custom instruction with funct3 = 3'b010 asserts sel_update_o, rd_read_o and wb_en_o in the same cycle. rd_idx_o then equals instr_i[11:7].
- R5: A custom instruction with funct3 = 3'b011 asserts sel_decay_o and wb_en_o in the same cycle. rd_read_o stays low.
- R6: A custom instruction with funct3 in 3'b100..3'b111 asserts illegal_o. It asserts no select output and no write-back, and the configuration registers are left unchanged.
- R7: The two configuration loads assert neither wb_en_o nor any select output. The configuration registers hold their values in every cycle that carries no load, including cycles in which issue_i is low.
- R8: A synchronous active-high rst_i clears every configuration register to zero.
- R9: At most one of sel_alu_o, sel_update_o, sel_decay_o and illegal_o is high in any cycle. When issue_i is low, all of them, wb_en_o and rd_read_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| issue_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 32 | Instruction word |
| rs1_val_i | input | 32 | First source operand value |
| rs2_val_i | input | 32 | Second source operand value |
| sel_alu_o | output | 1 | Route to standard ALU |
| sel_update_o | output | 1 | Route to neuron update unit |
| sel_decay_o | output | 1 | Route to decay unit |
| illegal_o | output | 1 | Unused custom-0 funct3 code |
| wb_en_o | output | 1 | Result is written to the register file |
| rd_read_o | output | 1 | Destination register is read as the state source |
| rd_idx_o | output | 5 | Destination register index |
| cfg_a_o | output | 16 | Coefficient a |
| cfg_b_o | output | 16 | Coefficient b |
| cfg_c_o | output | 16 | Reset potential c |
| cfg_d_o | output | 16 | Recovery increment d |
| cfg_step_o | output | 1 | Step-size select |
| cfg_clamp_o | output | 1 | Voltage clamp flag |
| cfg_tau_o | output | 2 | Decay time constant select |

## Verification
The bench builds the block with its default parameters. These are a 32-bit word, 16-bit coefficients and a 2-bit time constant select, so each coefficient fills exactly one half of an operand. The operand patterns used have different, non-zero halves. This exposes any swapped or shifted half, and any mix-up between rs1 and rs2. The bench covers all eight funct3 codes, a neighbouring non-custom opcode, and custom words presented with the issue strobe low. It also places a reset between two loads, which shows that a reset clears the configuration registers and that they persist between loads.

// File: rtl/nm_dispatch.sv
module nm_dispatch #(
  parameter int XLEN = 32,
  parameter int PW   = 16,
  parameter int TAUW = 2,
  parameter int RIW  = 5
) (
  input  logic            clk,
  input  logic            rst_i,
  input  logic            issue_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] rs1_val_i,
  input  logic [XLEN-1:0] rs2_val_i,
  output logic            sel_alu_o,
  output logic            sel_update_o,
  output logic            sel_decay_o,
  output logic            illegal_o,
  output logic            wb_en_o,
  output logic            rd_read_o,
  output logic [RIW-1:0]  rd_idx_o,
  output logic [PW-1:0]   cfg_a_o,
  output logic [PW-1:0]   cfg_b_o,
  output logic [PW-1:0]   cfg_c_o,
  output logic [PW-1:0]   cfg_d_o,
  output logic            cfg_step_o,
  output logic            cfg_clamp_o,
  output logic [TAUW-1:0] cfg_tau_o
);
  localparam logic [6:0] OPC_CUST = 7'b0001011;
  localparam int TAU_LO = 2;
  localparam int TAU_HI = TAU_LO + TAUW - 1;

  logic       is_cust;
  logic [2:0] f3;
  logic       ld_par, ld_stp;

  assign f3      = instr_i[14:12];
  assign is_cust = issue_i && (instr_i[6:0] == OPC_CUST);
  assign ld_par  = is_cust && (f3 == 3'b000);
  assign ld_stp  = is_cust && (f3 == 3'b001);

  assign sel_alu_o    = issue_i && !is_cust;
  assign sel_update_o = is_cust && (f3 == 3'b010);
  assign sel_decay_o  = is_cust && (f3 == 3'b011);
  assign illegal_o    = is_cust && f3[2];
  assign wb_en_o      = sel_update_o || sel_decay_o;
  assign rd_read_o    = sel_update_o;
  assign rd_idx_o     = instr_i[7+RIW-1:7];

  always_ff @(posedge clk) begin
    if (rst_i) begin
      cfg_a_o     <= '0;
      cfg_b_o     <= '0;
      cfg_c_o     <= '0;
      cfg_d_o     <= '0;
      cfg_step_o  <= 1'b0;
      cfg_clamp_o <= 1'b0;
      cfg_tau_o   <= '0;
    end else begin
      if (ld_par) begin
        cfg_a_o <= rs1_val_i[2*PW-1:PW];
        cfg_b_o <= rs1_val_i[PW-1:0];
        cfg_c_o <= rs2_val_i[2*PW-1:PW];
        cfg_d_o <= rs2_val_i[PW-1:0];
      end
      if (ld_stp) begin
        cfg_step_o  <= rs1_val_i[0];
        cfg_clamp_o <= rs1_val_i[1];
        cfg_tau_o   <= rs1_val_i[TAU_HI:TAU_LO];
      end
    end
  end

  p_one_route_r9: assert property (@(posedge clk) disable iff (rst_i)
    $onehot0({sel_alu_o, sel_update_o, sel_decay_o, illegal_o}));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst_i)
    !issue_i |-> !(sel_alu_o || sel_update_o || sel_decay_o || illegal_o || wb_en_o || rd_read_o));

  p_alu_only_r1: assert property (@(posedge clk) disable iff (rst_i)
    sel_alu_o |-> !wb_en_o && !rd_read_o);

  p_par_load_r2: assert property (@(posedge clk) disable iff (rst_i)
    ld_par |=> cfg_a_o == $past(rs1_val_i[2*PW-1:PW]) && cfg_b_o == $past(rs1_val_i[PW-1:0])
            && cfg_c_o == $past(rs2_val_i[2*PW-1:PW]) && cfg_d_o == $past(rs2_val_i[PW-1:0]));

  p_step_load_r3: assert property (@(posedge clk) disable iff (rst_i)
    ld_stp |=> cfg_step_o == $past(rs1_val_i[0]) && cfg_clamp_o == $past(rs1_val_i[1])
            && $stable(cfg_a_o) && $stable(cfg_d_o));

  p_update_wb_r4: assert property (@(posedge clk) disable iff (rst_i)
    sel_update_o |-> wb_en_o && rd_read_o);

  p_decay_wb_r5: assert property (@(posedge clk) disable iff (rst_i)
    sel_decay_o |-> wb_en_o && !rd_read_o);

  p_illegal_quiet_r6: assert property (@(posedge clk) disable iff (rst_i)
    illegal_o |-> !wb_en_o ##1 ($stable(cfg_a_o) && $stable(cfg_tau_o) && $stable(cfg_clamp_o)));

  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst_i)
    !(ld_par || ld_stp) |=> $stable(cfg_a_o) && $stable(cfg_b_o) && $stable(cfg_c_o)
            && $stable(cfg_d_o) && $stable(cfg_step_o) && $stable(cfg_clamp_o) && $stable(cfg_tau_o));

  p_load_no_wb_r7: assert property (@(posedge clk) disable iff (rst_i)
    (ld_par || ld_stp) |-> !wb_en_o);

  p_reset_clear_r8: assert property (@(posedge clk)
    rst_i |=> cfg_a_o == '0 && cfg_b_o == '0 && cfg_c_o == '0 && cfg_d_o == '0
            && !cfg_step_o && !cfg_clamp_o && cfg_tau_o == '0);
endmodule

// File: tb/nm_dispatch_tb.sv
module nm_dispatch_tb;
  logic clk = 1'b0;
  logic rst_i = 1'b1, issue_i = 1'b0;
  logic [31:0] instr_i = '0, rs1_val_i = '0, rs2_val_i = '0;
  logic sel_alu_o, sel_update_o, sel_decay_o, illegal_o, wb_en_o, rd_read_o;
  logic [4:0] rd_idx_o;
  logic [15:0] cfg_a_o, cfg_b_o, cfg_c_o, cfg_d_o;
  logic cfg_step_o, cfg_clamp_o;
  logic [1:0] cfg_tau_o;

  always #5 clk = ~clk;

  nm_dispatch u_dut (.*);

  typedef struct {
    string tag;
    logic [5:0] dec;
    logic [4:0] rd;
    logic [67:0] cfg;
  } item_t;

  item_t q[$];
  int tests = 0, fails = 0;
  logic [15:0] m_a = 0, m_b = 0, m_c = 0, m_d = 0;
  logic m_step = 0, m_clamp = 0;
  logic [1:0] m_tau = 0;
  bit done = 0;

  function automatic logic [31:0] mk(logic [6:0] opc, logic [2:0] f3, logic [4:0] rd);
    return {7'h15, 5'd9, 5'd3, f3, rd, opc};
  endfunction

  task automatic chk(string tag, string what, logic [67:0] act, logic [67:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic r, logic iss, logic [31:0] ins, logic [31:0] a, logic [31:0] b);
    item_t it;
    logic cust;
    @(negedge clk);
    rst_i = r; issue_i = iss; instr_i = ins; rs1_val_i = a; rs2_val_i = b;
    cust = iss && ins[6:0] == 7'b0001011;
    it.tag = tag;
    it.dec = {iss && !cust, cust && ins[14:12] == 3'd2, cust && ins[14:12] == 3'd3,
              cust && ins[14], cust && ins[14:13] == 2'b01, cust && ins[14:12] == 3'd2};
    it.rd = ins[11:7];
    if (r) begin
      m_a = 0; m_b = 0; m_c = 0; m_d = 0; m_step = 0; m_clamp = 0; m_tau = 0;
    end else if (cust && ins[14:12] == 3'd0) begin
      m_a = a[31:16]; m_b = a[15:0]; m_c = b[31:16]; m_d = b[15:0];
    end else if (cust && ins[14:12] == 3'd1) begin
      m_step = a[0]; m_clamp = a[1]; m_tau = a[3:2];
    end
    it.cfg = {m_a, m_b, m_c, m_d, m_step, m_clamp, m_tau};
    q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk); #3;
      if (q.size() != 0) begin
        it = q.pop_front();
        chk(it.tag, "route", {62'd0, sel_alu_o, sel_update_o, sel_decay_o, illegal_o, wb_en_o, rd_read_o}, {62'd0, it.dec});
        if (it.dec[0]) chk(it.tag, "rd_idx", {63'd0, rd_idx_o}, {63'd0, it.rd});
        @(posedge clk); #1;
        chk(it.tag, "cfg", {cfg_a_o, cfg_b_o, cfg_c_o, cfg_d_o, cfg_step_o, cfg_clamp_o, cfg_tau_o}, it.cfg);
      end
    end
  end

  localparam logic [6:0] C0 = 7'b0001011;

  initial begin : driver
    step("R8", 1, 0, '0, '0, '0);
    step("R8", 1, 1, mk(C0, 3'd0, 5'd1), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    step("R2", 0, 1, mk(C0, 3'd0, 5'd5), 32'h1234_5678, 32'h9ABC_DEF0);
    step("R9", 0, 0, mk(C0, 3'd0, 5'd5), 32'hAAAA_5555, 32'h0F0F_F0F0);
    step("R9", 0, 0, mk(C0, 3'd1, 5'd5), 32'h0000_000F, 32'h0);
    step("R3", 0, 1, mk(C0, 3'd1, 5'd2), 32'hFFFF_FFFD, 32'h1111_1111);
    step("R4", 0, 1, mk(C0, 3'd2, 5'd7), 32'h0000_0002, 32'h0);
    step("R5", 0, 1, mk(C0, 3'd3, 5'd31), 32'h0000_0000, 32'h0);
    for (int f = 4; f < 8; f++)
      step("R6", 0, 1, mk(C0, 3'(f), 5'd12), 32'hDEAD_BEEF, 32'hCAFE_F00D);
    step("R1", 0, 1, mk(7'b0110011, 3'd0, 5'd4), 32'h7777_7777, 32'h8888_8888);
    step("R1", 0, 1, mk(7'b0101011, 3'd1, 5'd4), 32'h0000_000E, 32'h0);
    step("R1", 0, 1, mk(7'b0001010, 3'd0, 5'd4), 32'h4444_4444, 32'h0);
    step("R7", 0, 1, mk(C0, 3'd3, 5'd8), 32'h0, 32'h0);
    step("R7", 0, 0, '0, '0, '0);
    step("R2", 0, 1, mk(C0, 3'd0, 5'd0), 32'h8001_7FFE, 32'h0102_0304);
    step("R3", 0, 1, mk(C0, 3'd1, 5'd0), 32'h0000_0006, 32'h0);
    step("R8", 1, 0, '0, '0, '0);
    step("R7", 0, 0, '0, '0, '0);
    step("R3", 0, 1, mk(C0, 3'd1, 5'd0), 32'h0000_0001, 32'h0);
    step("R7", 0, 1, mk(C0, 3'd2, 5'd19), 32'h0, 32'h0);
    step("R7", 0, 0, '0, '0, '0);
    repeat (3) @(posedge clk);
    done = 1;
  end

  initial begin : finisher
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule